// File: doc/BRIEF.md
# One-Hot Population Tally

This block counts the set bits of a parameterised input word and reports the result as a one-hot vector rather than a binary number. It is built from a chain of identical steering cells, one cell per input bit. Each cell takes a one-hot "count so far" vector. If its bit is clear, the cell passes every line through to the same position. If its bit is set, the cell moves every line up by one position.

The chain starts with only the lowest line (count zero) asserted. After the last cell, exactly one of the WIDTH+1 output lines is high, and its index equals the number of ones in the input. The lowest line of a cell that shifts has no source, so it is tied low and every line always holds a defined level.

An optional output register, selected by a parameter and on by default, captures the result on the rising clock edge. A synchronous active-low reset puts it into the count-zero state. Typical uses are thermometer-to-select conversion, arbitration weighting, or any consumer that wants a decoded count line without a binary adder tree followed by a decoder.

Top module: `tally_onehot`

## Requirements
- R1: An all-zero input word produces an output with only bit 0 asserted.
- R2: A clear input bit leaves the running count position unchanged, so adding zero bits to a word never moves the asserted line.
- R3: A set input bit moves the running count up by exactly one position. Bit 0 of the vector after such a cell is 0, because no path reaches it.
- R4: For every input pattern, exactly one output line is asserted.
- R5: The index of the asserted output line equals the number of 1 bits in the input, for all 2^WIDTH patterns at the default WIDTH of 8 (9 output lines).
- R6: An all-ones input asserts only the top line, bit WIDTH.
- R7: With REGISTERED=1, the output shows the tally of the input that was present at the previous rising clock edge, and it holds its value between edges.
- R8: With REGISTERED=1, a rising edge with rstN low loads the count-zero state (only bit 0 set), whatever the input is in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rstN | input | 1 | Synchronous active-low reset; loads the count-zero state |
| dataIn | input | WIDTH | Word whose set bits are counted |
| tallyOut | output | WIDTH+1 | One-hot tally; bit k high means k input bits are set |

## Verification
Two functions can act in the same cycle: the reset and the capture of a non-zero tally. The bench provokes this by holding rstN low while dataIn is all ones, both at start-up and again in the middle of the exhaustive sweep. The register must then show the count-zero line and not the top line. After rstN is released, the next pattern must be captured normally. This shows that the reset takes priority for one cycle only and does not hide the capture that follows.

// File: rtl/tally_pkg.sv
package tally_pkg;

  // Strobes from the control module to the datapath register.
  typedef struct packed {
    logic capture;    // load the steering result into the output register
    logic forceZero;  // load the count-zero pattern instead
  } tallyStrobe_t;

  // One-hot vector with only the count-zero line asserted.
  function automatic logic [63:0] zeroLine();
    return 64'd1;
  endfunction

endpackage

// File: rtl/tally_stage.sv
// One steering cell: pass straight when the bit is clear, move diagonally up one
// position when it is set. The lowest line has no diagonal source and is tied low.
module tally_stage #(
  parameter int COUNTW = 9
) (
  input  logic              bitIn,
  input  logic [COUNTW-1:0] countIn,
  output logic [COUNTW-1:0] countOut
);

  logic [COUNTW-1:0] straightPath;
  logic [COUNTW-1:0] diagonalPath;

  always_comb begin
    straightPath = countIn;
    diagonalPath = '0;
    for (int k = 1; k < COUNTW; k++) begin
      diagonalPath[k] = countIn[k-1];
    end
  end

  assign countOut = bitIn ? diagonalPath : straightPath;

endmodule

// File: rtl/tally_ctrl.sv
// Turns the reset pin into strobes for the datapath register.
module tally_ctrl
  import tally_pkg::*;
(
  input  logic         rstN,
  output tallyStrobe_t strobes
);

  always_comb begin
    strobes.forceZero = ~rstN;
    strobes.capture   = rstN;
  end

endmodule

// File: rtl/tally_datapath.sv
// Cascade of steering cells plus the optional output register.
module tally_datapath
  import tally_pkg::*;
#(
  parameter int WIDTH      = 8,
  parameter bit REGISTERED = 1'b1
) (
  input  logic             clk,
  input  logic             rstN,
  input  tallyStrobe_t     strobes,
  input  logic [WIDTH-1:0] dataIn,
  output logic [WIDTH:0]   tallyOut
);

  localparam int COUNTW = WIDTH + 1;

  logic [COUNTW-1:0] chain [WIDTH+1];
  logic [COUNTW-1:0] startVec;

  assign startVec = COUNTW'(zeroLine());
  assign chain[0] = startVec;

  for (genvar i = 0; i < WIDTH; i++) begin : g_cell
    tally_stage #(.COUNTW(COUNTW)) u_cell (
      .bitIn   (dataIn[i]),
      .countIn (chain[i]),
      .countOut(chain[i+1])
    );

    // A clear bit keeps the running position.
    assert_straight_R2: assert property (@(posedge clk) disable iff (!rstN)
      !dataIn[i] |-> chain[i+1] == chain[i]);

    // A set bit vacates line 0 and moves the running count up.
    assert_diagonal_R3: assert property (@(posedge clk) disable iff (!rstN)
      dataIn[i] |-> (!chain[i+1][0] && chain[i+1][COUNTW-1:1] == chain[i][COUNTW-2:0]));
  end

  logic [COUNTW-1:0] tallyComb;
  assign tallyComb = chain[WIDTH];

  assert_onehot_comb_R4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot(tallyComb));

  assert_zero_input_R1: assert property (@(posedge clk) disable iff (!rstN)
    dataIn == '0 |-> tallyComb == startVec);

  assert_all_ones_R6: assert property (@(posedge clk) disable iff (!rstN)
    &dataIn |-> tallyComb[WIDTH]);

  if (REGISTERED) begin : g_reg
    logic [COUNTW-1:0] tallyQ;

    always_ff @(posedge clk) begin
      if (strobes.forceZero) begin
        tallyQ <= startVec;
      end else if (strobes.capture) begin
        tallyQ <= tallyComb;
      end
    end

    assign tallyOut = tallyQ;

    assert_capture_latency_R7: assert property (@(posedge clk) disable iff (!rstN)
      strobes.capture |=> tallyQ == $past(tallyComb));

    assert_onehot_reg_R4: assert property (@(posedge clk) disable iff (!rstN)
      strobes.capture |=> $onehot(tallyQ));
  end else begin : g_comb
    assign tallyOut = tallyComb;
  end

endmodule

// File: rtl/tally_onehot.sv
// Thin top: control strobes plus the steering datapath.
module tally_onehot
  import tally_pkg::*;
#(
  parameter int WIDTH      = 8,
  parameter bit REGISTERED = 1'b1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] dataIn,
  output logic [WIDTH:0]   tallyOut
);

  tallyStrobe_t strobes;

  tally_ctrl u_ctrl (
    .rstN   (rstN),
    .strobes(strobes)
  );

  tally_datapath #(.WIDTH(WIDTH), .REGISTERED(REGISTERED)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .dataIn  (dataIn),
    .tallyOut(tallyOut)
  );

endmodule

// File: tb/tally_onehot_tb.sv
module tally_onehot_tb;

  localparam int WIDTH = 8;

  typedef struct {
    logic [WIDTH:0] expVal;
    string          tag;
  } scoreItem_t;

  logic             clk = 1'b0;
  logic             rstN;
  logic [WIDTH-1:0] dataIn;
  logic [WIDTH:0]   tallyOut;

  scoreItem_t scoreQ[$];
  int testCount = 0;
  int failCount = 0;
  bit driverDone = 1'b0;
  logic [WIDTH:0] lastExp;

  always #4 clk = ~clk;  // 125 MHz

  tally_onehot #(.WIDTH(WIDTH), .REGISTERED(1'b1)) u_dut (
    .clk     (clk),
    .rstN    (rstN),
    .dataIn  (dataIn),
    .tallyOut(tallyOut)
  );

  function automatic logic [WIDTH:0] refTally(input logic [WIDTH-1:0] v);
    int pc = 0;
    for (int b = 0; b < WIDTH; b++) pc += int'(v[b]);
    return (WIDTH+1)'(1) << pc;
  endfunction

  function automatic string pickTag(input logic [WIDTH-1:0] v);
    int pc = 0;
    for (int b = 0; b < WIDTH; b++) pc += int'(v[b]);
    if (v == '0) return "R1 zero input";
    if (&v) return "R6 all ones";
    if (pc == 1) return "R3 single set bit";
    if (!v[WIDTH-1]) return "R5 popcount, R2 top bit clear";
    return "R5 popcount";
  endfunction

  task automatic drive(input logic r, input logic [WIDTH-1:0] v, input string tag);
    scoreItem_t it;
    @(negedge clk);
    rstN   = r;
    dataIn = v;
    it.expVal = r ? refTally(v) : (WIDTH+1)'(1);
    it.tag    = tag;
    scoreQ.push_back(it);
    // R7: before the next edge the output still shows the previous result
    #1;
    testCount++;
    if (tallyOut !== lastExp) begin
      failCount++;
      $display("FAIL R7 hold before edge: actual %b expected %b", tallyOut, lastExp);
    end
    lastExp = it.expVal;
  endtask

  // Monitor: pop and compare just after each capturing edge.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (scoreQ.size() > 0) begin
        scoreItem_t it;
        it = scoreQ.pop_front();
        testCount++;
        if (tallyOut !== it.expVal) begin
          failCount++;
          $display("FAIL %s: actual %b expected %b", it.tag, tallyOut, it.expVal);
        end
        testCount++;
        if ($countones(tallyOut) != 1) begin
          failCount++;
          $display("FAIL R4 one-hot: actual %b expected one line set", tallyOut);
        end
      end
    end
  end

  // Driver
  initial begin
    rstN    = 1'b0;
    dataIn  = '1;
    lastExp = (WIDTH+1)'(1);
    // R8: reset with all ones present at the same edge
    drive(1'b0, '1, "R8 reset with all ones");
    drive(1'b0, '1, "R8 reset with all ones");
    for (int p = 0; p < (1 << WIDTH); p++) begin
      drive(1'b1, WIDTH'(p), pickTag(WIDTH'(p)));
      if (p == 100) begin
        drive(1'b0, '1, "R8 mid-run reset with all ones");
        drive(1'b1, 8'h80, "R3 capture after reset release");
      end
    end
    // R2: trailing zero bits do not move the line
    drive(1'b1, 8'h03, "R2 low bits only");
    drive(1'b1, 8'h00, "R1 zero after data");
    drive(1'b1, 8'hFF, "R6 all ones again");
    driverDone = 1'b1;
  end

  initial begin
    wait (driverDone && scoreQ.size() == 0);
    @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    failCount++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

endmodule